// File: doc/BRIEF.md
# Clock Output Reset and Release Sequencer

This block merges four reset sources into one internal reset for a clock generator and decides when the clock outputs may toggle again. The four sources are a power-on pulse, an active-low hard reset pin, a pair of soft-reset bits in a control register, and a soft request to reload settings from nonvolatile storage. On every reset it asks the settings store to restore the chip. The restore source is taken from a storage-select pin, or is always storage for a reload request. When the restore finishes, the block holds the outputs in sync for a delay. The length of that delay depends on what caused the reset and which source was used. After the delay it enables the outputs.

The reset pin takes effect at once and is let go through a synchronizer. The soft-reset bits stay set until one more rising edge of the serial clock after the write. All other bits of the control register keep their values across a soft reset. Every delay is a cycle-count parameter, so a short configuration can be used.

Top module: `clk_rst_seq`

## Requirements
- R1: While rst_ni is low, int_rst_o is 1, out_en_o, sync_o and restore_req_o are 0, and ctrl_rdata_o reads CTRL_DEF (default 8'h18). After rst_ni rises, restore_req_o stays 0 for two rising clock edges and is 1 after the third.
- R2: restore_src_o (1 = storage, 0 = built-in defaults) equals nvm_sel_i for power-on, pin and soft resets. It is 1 for a reload request.
- R3: restore_req_o stays high until restore_done_i is sampled high. Both this wait and the reset hold before it keep int_rst_o high.
- R4: After restore_done_i, sync_o is high for exactly D clock cycles, and out_en_o rises in the next cycle. D is T_POR_CYC after power-on. After a pin or soft reset, D is T_NVM_CYC when the source is storage and T_DEF_CYC when it is the defaults. D is T_NVM_CYC after a reload.
- R5: A soft reset starts only when a write leaves control bits 2 and 5 both set. A write that sets only one of them is stored as written, and out_en_o stays 1.
- R6: After a soft-reset write, bits 2 and 5 read back as 1 and int_rst_o stays high with out_en_o low. This lasts until a rising edge of sclk_i. After that edge both bits read 0 and the restore begins.
- R7: A soft reset leaves every other control bit unchanged. Power-on and pin resets load CTRL_DEF.
- R8: A pulse on reload_req_i while the outputs run and nvm_sel_i is 0 starts a restore from storage. When nvm_sel_i is 1 the pulse is ignored: out_en_o stays 1 and no request is raised.
- R9: A power-on pulse or a soft reset during the sync delay returns the block to reset hold. The next release counts its full delay again.
- R10: out_en_o is 0 whenever int_rst_o or sync_o is 1. It rises only directly after a sync phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Hard reset pin, active low, asserted asynchronously |
| por_i | input | 1 | Power-on reset pulse, active high, synchronous |
| nvm_sel_i | input | 1 | Storage select: 1 restores from storage, 0 from defaults |
| sclk_i | input | 1 | Serial port clock, oversampled |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | CTRL_W | Control register write data |
| ctrl_rdata_o | output | CTRL_W | Control register contents |
| reload_req_i | input | 1 | Soft request to reload settings from storage |
| restore_req_o | output | 1 | Restore request to the settings store |
| restore_src_o | output | 1 | Restore source for the request |
| restore_done_i | input | 1 | Settings store reports restore finished |
| int_rst_o | output | 1 | Internal reset for the clock chip |
| sync_o | output | 1 | Outputs held in sync phase |
| out_en_o | output | 1 | Clock outputs allowed to toggle |

## Verification
The assertions take several things for granted about the inputs. por_i and the register write port are synchronous to clk_i. sclk_i changes slowly enough to be oversampled. restore_done_i is pulsed only while a request is open, and nvm_sel_i is stable when the reset hold ends. The bench stays inside these limits. It holds every sclk_i level for six clock cycles and drives restore_done_i only after it has seen restore_req_o. It changes nvm_sel_i only while the outputs run or while the block is in reset hold, and it makes no register writes during a reset hold except the soft-reset write under test.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;
  typedef enum logic [1:0] {
    ST_HOLD,
    ST_RESTORE,
    ST_DELAY,
    ST_RUN
  } seq_state_e;

  typedef enum logic [1:0] {
    CAUSE_POR,
    CAUSE_PIN,
    CAUSE_SOFT,
    CAUSE_RELOAD
  } rst_cause_e;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= RST_VAL;
      else         st_q <= d_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= {STAGES{RST_VAL}};
      else         st_q <= {st_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/cs_ctrl_reg.sv
module cs_ctrl_reg #(
  parameter int           W     = 8,
  parameter logic [W-1:0] DEF   = '0,
  parameter int           BIT_A = 2,
  parameter int           BIT_B = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         por_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         sclk_rise_i,
  output logic [W-1:0] q_o,
  output logic         soft_pend_o
);
  localparam logic [W-1:0] MASK = (W'(1) << BIT_A) | (W'(1) << BIT_B);

  logic [W-1:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          reg_q <= DEF;
    else if (por_i)                       reg_q <= DEF;
    else if (we_i)                        reg_q <= wdata_i;
    else if (soft_pend_o && sclk_rise_i)  reg_q <= reg_q & ~MASK;
  end

  assign q_o         = reg_q;
  assign soft_pend_o = reg_q[BIT_A] & reg_q[BIT_B];

  AST_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_pend_o && sclk_rise_i && !we_i && !por_i) |=> !soft_pend_o); // R6
  AST_PEND_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_pend_o && !sclk_rise_i && !we_i && !por_i) |=> soft_pend_o); // R6
  AST_KEEP_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !por_i) |=> ((q_o & ~MASK) == $past(q_o & ~MASK))); // R7
endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
  import clk_seq_pkg::*;
#(
  parameter int T_POR = 3500000,
  parameter int T_DEF = 100,
  parameter int T_NVM = 2000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ok_i,
  input  logic por_i,
  input  logic soft_pend_i,
  input  logic nvm_sel_i,
  input  logic reload_i,
  input  logic restore_done_i,
  output logic restore_req_o,
  output logic restore_src_o,
  output logic int_rst_o,
  output logic sync_o,
  output logic out_en_o
);
  localparam int MAX_A = (T_POR > T_DEF) ? T_POR : T_DEF;
  localparam int MAX_T = (MAX_A > T_NVM) ? MAX_A : T_NVM;
  localparam int CNT_W = $clog2(MAX_T + 1);

  seq_state_e       state_q;
  rst_cause_e       cause_q;
  logic             src_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dly;

  always_comb begin
    unique case (cause_q)
      CAUSE_POR:    dly = CNT_W'(T_POR);
      CAUSE_RELOAD: dly = CNT_W'(T_NVM);
      default:      dly = src_q ? CNT_W'(T_NVM) : CNT_W'(T_DEF);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cause_q <= CAUSE_PIN;
      src_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (por_i) begin
      state_q <= ST_HOLD;
      cause_q <= CAUSE_POR;
    end else if (soft_pend_i) begin
      state_q <= ST_HOLD;
      cause_q <= CAUSE_SOFT;
    end else begin
      unique case (state_q)
        ST_HOLD: if (pin_ok_i) begin
          state_q <= ST_RESTORE;
          src_q   <= nvm_sel_i;
        end
        ST_RESTORE: if (restore_done_i) begin
          state_q <= ST_DELAY;
          cnt_q   <= dly - CNT_W'(1);
        end
        ST_DELAY: begin
          if (cnt_q == '0) state_q <= ST_RUN;
          else             cnt_q   <= cnt_q - CNT_W'(1);
        end
        ST_RUN: if (reload_i && !nvm_sel_i) begin
          state_q <= ST_RESTORE;
          cause_q <= CAUSE_RELOAD;
          src_q   <= 1'b1;
        end
      endcase
    end
  end

  assign restore_req_o = (state_q == ST_RESTORE);
  assign restore_src_o = src_q;
  assign int_rst_o     = (state_q == ST_HOLD) || (state_q == ST_RESTORE);
  assign sync_o        = (state_q == ST_DELAY);
  assign out_en_o      = (state_q == ST_RUN);

  AST_PIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_ok_i |-> (int_rst_o && !restore_req_o)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_req_o && !restore_done_i && !por_i && !soft_pend_i) |=> restore_req_o); // R3
  AST_SYNC_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_en_o) |-> $past(sync_o)); // R10
  AST_RELOAD_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_o && nvm_sel_i && !por_i && !soft_pend_i) |=> out_en_o); // R8
  AST_POR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (int_rst_o && !sync_o && !out_en_o)); // R9
endmodule

// File: rtl/clk_rst_seq.sv
module clk_rst_seq #(
  parameter int                CTRL_W      = 8,
  parameter logic [CTRL_W-1:0] CTRL_DEF    = CTRL_W'('h18),
  parameter int                SRST_BIT_A  = 2,
  parameter int                SRST_BIT_B  = 5,
  parameter int                SYNC_STAGES = 2,
  parameter int                T_POR_CYC   = 3500000,
  parameter int                T_DEF_CYC   = 100,
  parameter int                T_NVM_CYC   = 2000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              nvm_sel_i,
  input  logic              sclk_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  input  logic              reload_req_i,
  output logic              restore_req_o,
  output logic              restore_src_o,
  input  logic              restore_done_i,
  output logic              int_rst_o,
  output logic              sync_o,
  output logic              out_en_o
);
  logic pin_ok;
  logic sclk_s;
  logic sclk_d;
  logic sclk_rise;
  logic soft_pend;

  cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (pin_ok)
  );

  cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sclk_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sclk_i),
    .q_o   (sclk_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s;
  end
  assign sclk_rise = sclk_s & ~sclk_d;

  cs_ctrl_reg #(
    .W    (CTRL_W),
    .DEF  (CTRL_DEF),
    .BIT_A(SRST_BIT_A),
    .BIT_B(SRST_BIT_B)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_i      (por_i),
    .we_i       (ctrl_we_i),
    .wdata_i    (ctrl_wdata_i),
    .sclk_rise_i(sclk_rise),
    .q_o        (ctrl_rdata_o),
    .soft_pend_o(soft_pend)
  );

  cs_seq_fsm #(
    .T_POR(T_POR_CYC),
    .T_DEF(T_DEF_CYC),
    .T_NVM(T_NVM_CYC)
  ) i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pin_ok_i      (pin_ok),
    .por_i         (por_i),
    .soft_pend_i   (soft_pend),
    .nvm_sel_i     (nvm_sel_i),
    .reload_i      (reload_req_i),
    .restore_done_i(restore_done_i),
    .restore_req_o (restore_req_o),
    .restore_src_o (restore_src_o),
    .int_rst_o     (int_rst_o),
    .sync_o        (sync_o),
    .out_en_o      (out_en_o)
  );

  AST_SOFT_STATIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_pend |=> (!out_en_o && int_rst_o)); // R6
endmodule

// File: tb/test_clk_rst_seq.sv
`timescale 1ns/1ps
module test_clk_rst_seq;
  localparam int TP = 20;
  localparam int TD = 5;
  localparam int TN = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por = 1'b0;
  logic       sel = 1'b0;
  logic       sclk = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       reload = 1'b0;
  logic       req, src;
  logic       done = 1'b0;
  logic       irst, syn, oen;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;

  always #(TP_HALF) clk = ~clk;
  localparam int TP_HALF = 10;

  clk_rst_seq #(
    .T_POR_CYC(TP), .T_DEF_CYC(TD), .T_NVM_CYC(TN)
  ) i_clk_rst_seq (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por), .nvm_sel_i(sel), .sclk_i(sclk),
    .ctrl_we_i(we), .ctrl_wdata_i(wdata), .ctrl_rdata_o(rdata),
    .reload_req_i(reload), .restore_req_o(req), .restore_src_o(src),
    .restore_done_i(done), .int_rst_o(irst), .sync_o(syn), .out_en_o(oen)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] v);
    we = 1'b1; wdata = v;
    tick(1);
    we = 1'b0;
  endtask

  task automatic pulse_por();
    por = 1'b1;
    tick(2);
    por = 1'b0;
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1; tick(6);
    sclk = 1'b0; tick(6);
  endtask

  task automatic open_delay(int exp_src, string tag);
    for (int i = 0; i < 40 && !req; i++) tick(1);
    chk({tag, " R3 request raised"}, int'(req), 1);
    chk({tag, " R2 restore source"}, int'(src), exp_src);
    tick(3);
    chk({tag, " R3 request held"}, int'(req), 1);
    chk({tag, " R3 internal reset held"}, int'(irst), 1);
    chk({tag, " R10 outputs off in restore"}, int'(oen), 0);
    done = 1'b1;
    tick(1);
    done = 1'b0;
  endtask

  task automatic finish_seq(int exp_src, int exp_d, string tag);
    int n;
    open_delay(exp_src, tag);
    n = 0;
    while (!oen && n < 500) begin
      if (syn) n++;
      else if (!oen) n += 1000;
      tick(1);
    end
    chk({tag, " R4 sync length"}, n, exp_d);
    chk({tag, " R10 reset off when running"}, int'(irst), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(TP_HALF * 2 * 200000);
    if (!ended) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 int_rst in reset", int'(irst), 1);
    chk("R1 out_en in reset", int'(oen), 0);
    chk("R1 sync in reset", int'(syn), 0);
    chk("R1 req in reset", int'(req), 0);
    chk("R1 ctrl default", int'(rdata), 'h18);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R1 req after two edges", int'(req), 0);
    @(negedge clk);
    chk("R1 req after third edge", int'(req), 1);
    finish_seq(0, TD, "R1 first release");

    // pin reset for both storage modes
    for (int s = 0; s < 2; s++) begin
      wr(8'h81);
      sel = s[0];
      rst_n = 1'b0;
      tick(2);
      chk("R10 out_en low during pin reset", int'(oen), 0);
      chk("R7 pin reset loads default", int'(rdata), 'h18);
      rst_n = 1'b1;
      finish_seq(s, s ? TN : TD, "R4 pin");
    end

    // power-on pulse for both storage modes
    for (int s = 0; s < 2; s++) begin
      sel = s[0];
      wr(8'h81);
      pulse_por();
      chk("R7 power-on loads default", int'(rdata), 'h18);
      finish_seq(s, TP, "R4 power-on");
    end

    // soft reset for both storage modes
    for (int s = 0; s < 2; s++) begin
      sel = s[0];
      wr(8'h81);
      wr(8'hA5);
      tick(8);
      chk("R6 bits held before sclk", int'(rdata), 'hA5);
      chk("R6 int_rst held before sclk", int'(irst), 1);
      chk("R6 outputs static before sclk", int'(oen), 0);
      chk("R6 no request before sclk", int'(req), 0);
      sclk = 1'b1; tick(6);
      sclk = 1'b0;
      chk("R7 soft reset keeps other bits", int'(rdata), 'h81);
      finish_seq(s, s ? TN : TD, "R4 soft");
    end

    // one soft bit alone does nothing
    begin
      logic [7:0] one [2];
      one[0] = 8'h04; one[1] = 8'h20;
      for (int k = 0; k < 2; k++) begin
        wr(one[k]);
        tick(6);
        chk("R5 single bit keeps running", int'(oen), 1);
        chk("R5 single bit no request", int'(req), 0);
        chk("R5 single bit stored", int'(rdata), int'(one[k]));
        sclk_pulse();
        chk("R5 single bit survives sclk", int'(rdata), int'(one[k]));
      end
    end

    // reload request
    sel = 1'b0;
    reload = 1'b1; tick(1); reload = 1'b0;
    finish_seq(1, TN, "R8 reload");
    sel = 1'b1;
    reload = 1'b1; tick(1); reload = 1'b0;
    tick(5);
    chk("R8 reload ignored out_en", int'(oen), 1);
    chk("R8 reload ignored no request", int'(req), 0);

    // restart during delay by power-on
    sel = 1'b0;
    pulse_por();
    open_delay(0, "R9 por restart");
    tick(4);
    chk("R9 in delay before restart", int'(syn), 1);
    pulse_por();
    chk("R9 por returns to hold", int'(irst), 1);
    finish_seq(0, TP, "R9 por full delay");

    // restart during delay by soft reset
    sel = 1'b1;
    pulse_por();
    open_delay(1, "R9 soft restart");
    tick(6);
    wr(8'hA4);
    tick(2);
    chk("R9 soft returns to hold", int'(irst), 1);
    chk("R9 soft outputs static", int'(oen), 0);
    sclk = 1'b1; tick(6); sclk = 1'b0;
    finish_seq(1, TN, "R9 soft full delay");

    ended = 1;
    summary();
    $finish;
  end
endmodule